// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block is the switching core of a serial time-division multiplexed switch with eight input streams and eight output streams. Each frame holds 32 byte-wide channels per stream. Every stream bit lasts two clocks, so a channel is 16 clocks and a frame is 512 clocks. An active-low frame pulse aligns the frame. The block turns each incoming serial channel into a byte and files it in a data memory under its stream and channel. There are two banks, one being filled and one holding the previous frame. For every outgoing channel, a per-channel connection word picks what to send. It is either a stored input byte from the last frame or a fixed message byte that repeats every frame.

Each outgoing channel also has its own driver-enable bit and a control bit. The control bits leave on a separate serial pin one channel ahead of the data they belong to. A global broadcast input puts every channel into enabled message mode. A driver-enable input, when low, turns all serial drivers off whatever else is set. A processor reaches the connection words and the data memory through plain write and read ports.

Top module: `tsi_switch`

## Requirements
- R1: A low `frame_n` at a rising edge makes the next clock the first clock of bit 0 of channel 0. Each bit lasts 2 clocks, each channel 16 clocks and each frame 512 clocks, and the count runs on freely between pulses.
- R2: Each serial input is sampled on the first clock of every bit period, most significant bit first. The received byte is stored at data-memory address {stream[2:0], channel[4:0]}.
- R3: An output channel whose high connection word has bit 2 = 0 sends its data MSB first. The data is the byte received in the previous frame at the address held in its low connection word, with bits 7..5 giving the source stream and bits 4..0 the source channel.
- R4: An output channel whose high connection word has bit 2 = 1 sends its low connection word every frame. A rewrite of that word is sent from the channel's next occurrence onward.
- R5: With `drive_en` high and `glb_msg` low, `ser_oe` for a stream stays equal to bit 0 of that channel's high connection word (1 = drive) for the whole 16-clock channel.
- R6: While `glb_msg` is high, every channel of every stream behaves as if bits 2 and 0 of its high connection word were both 1. The input is taken at the last clock before each channel.
- R7: While `drive_en` is low, every bit of `ser_oe` is 0, overriding R5 and R6.
- R8: During bit b of channel c, `cst_out` carries bit 1 of the high connection word of output stream b, channel (c+1) mod 32.
- R9: With `cm_we` high, `cm_wdata` is written at address {stream, channel} = `cm_addr`. It goes to the low word when `cm_sel_hi` = 0 and to the high word when `cm_sel_hi` = 1. The high word keeps only bits 2..0.
- R10: `rd_data` is valid one clock after `rd_sel`/`rd_addr` are presented. `rd_sel` 0 reads the data memory of the last completed frame, 1 the low word, 2 the high word (bits 7..3 read 0) and 3 gives 0.
- R11: Synchronous active-high `rst` clears both connection memories. After reset, `ser_oe` is 0 and `cst_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, two per serial bit |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Active-low frame alignment pulse |
| ser_in | input | 8 | Serial input streams |
| ser_out | output | 8 | Serial output data |
| ser_oe | output | 8 | Per-stream driver enable, 1 = drive |
| cst_out | output | 1 | Serial control-bit stream |
| glb_msg | input | 1 | Broadcast: all channels enabled message mode |
| drive_en | input | 1 | Low forces all drivers off |
| cm_we | input | 1 | Connection memory write strobe |
| cm_sel_hi | input | 1 | 0 = low word, 1 = high word |
| cm_addr | input | 8 | {output stream, channel} write address |
| cm_wdata | input | 8 | Write data |
| rd_sel | input | 2 | Read source select |
| rd_addr | input | 8 | {stream, channel} read address |
| rd_data | output | 8 | Registered read data |

## Verification
The bench builds the switch with its defaults: eight streams, 32 channels and two clocks per bit. With these values the low connection word is exactly the 8-bit data-memory address, and the control-bit pin walks all eight streams in one channel. This brings within reach the frame-wrap cases. These are a channel-31 source feeding channel 31, and the stream-7 control bit for channel 0 sent in the last channel of the previous frame. It also covers loading channel 0 from the bank that is still being filled in the closing frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int N_STREAMS_D    = 8;
    localparam int N_CHANNELS_D   = 32;
    localparam int CLKS_PER_BIT_D = 2;
    localparam int BYTE_W         = 8;

    typedef enum logic [1:0] {
        RD_DATA    = 2'd0,
        RD_CONN_LO = 2'd1,
        RD_CONN_HI = 2'd2,
        RD_NONE    = 2'd3
    } rd_sel_e;

    // Per-channel control held in the high connection word
    typedef struct packed {
        logic msg;    // word bit 2
        logic ctl;    // word bit 1
        logic drive;  // word bit 0
    } conn_hi_t;

    function automatic conn_hi_t hi_from_byte(input logic [BYTE_W-1:0] raw);
        conn_hi_t h;
        h.msg   = raw[2];
        h.ctl   = raw[1];
        h.drive = raw[0];
        return h;
    endfunction

    function automatic logic [BYTE_W-1:0] hi_to_byte(input conn_hi_t h);
        return {{(BYTE_W-3){1'b0}}, h.msg, h.ctl, h.drive};
    endfunction

    // Broadcast forces message mode and the driver on
    function automatic conn_hi_t hi_effective(input conn_hi_t h, input logic bcast);
        conn_hi_t e;
        e.msg   = h.msg   | bcast;
        e.ctl   = h.ctl;
        e.drive = h.drive | bcast;
        return e;
    endfunction

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
    import tsi_pkg::*;
#(
    parameter int N_CHANNELS   = N_CHANNELS_D,
    parameter int CLKS_PER_BIT = CLKS_PER_BIT_D
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frame_n,
    output logic [$clog2(N_CHANNELS)-1:0] ch,
    output logic [$clog2(BYTE_W)-1:0]     bit_idx,
    output logic [$clog2(N_CHANNELS)-1:0] nxt_ch,
    output logic [$clog2(BYTE_W)-1:0]     nxt_bit,
    output logic                          sample_en,
    output logic                          bit_end,
    output logic                          chan_end,
    output logic                          last_ch,
    output logic                          frame_par
);
    localparam int CW    = $clog2(N_CHANNELS);
    localparam int BW    = $clog2(BYTE_W);
    localparam int PW    = $clog2(CLKS_PER_BIT);
    localparam int CNT_W = CW + BW + PW;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PW-1:0]    ph;
    logic             par_q;

    assign cnt_d = frame_n ? cnt_q + 1'b1 : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '1;
            par_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (cnt_d == '0) par_q <= ~par_q;
        end
    end

    assign ph        = cnt_q[PW-1:0];
    assign bit_idx   = cnt_q[PW +: BW];
    assign ch        = cnt_q[PW+BW +: CW];
    assign nxt_bit   = cnt_d[PW +: BW];
    assign nxt_ch    = cnt_d[PW+BW +: CW];
    assign sample_en = (ph == '0);
    assign bit_end   = (ph == '1);
    assign chan_end  = bit_end && (bit_idx == '1);
    assign last_ch   = (ch == '1);
    assign frame_par = par_q;

    AST_FRAME_SYNC: assert property (@(posedge clk) disable iff (rst)
        !frame_n |=> (cnt_q == '0)) else $error("frame pulse did not realign"); // R1
    AST_BANK_FLIP: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '1) |=> (par_q != $past(par_q))) else $error("bank did not swap at frame end"); // R3

endmodule

// File: rtl/tsi_rx_store.sv
module tsi_rx_store
    import tsi_pkg::*;
#(
    parameter int N_STREAMS  = N_STREAMS_D,
    parameter int N_CHANNELS = N_CHANNELS_D
) (
    input  logic                                               clk,
    input  logic                                               rst,
    input  logic [N_STREAMS-1:0]                               ser_in,
    input  logic                                               sample_en,
    input  logic [$clog2(BYTE_W)-1:0]                          bit_idx,
    input  logic [$clog2(N_CHANNELS)-1:0]                      ch,
    input  logic                                               frame_par,
    input  logic                                               fetch_bank,
    input  logic [$clog2(N_STREAMS)+$clog2(N_CHANNELS)-1:0]    fetch_addr [N_STREAMS],
    output logic [BYTE_W-1:0]                                  fetch_data [N_STREAMS],
    input  logic [$clog2(N_STREAMS)+$clog2(N_CHANNELS)-1:0]    cpu_addr,
    output logic [BYTE_W-1:0]                                  cpu_data
);
    localparam int SW      = $clog2(N_STREAMS);
    localparam int AW      = SW + $clog2(N_CHANNELS);
    localparam int ENTRIES = N_STREAMS * N_CHANNELS;

    logic [BYTE_W-1:0] mem [2][ENTRIES];
    logic [BYTE_W-2:0] sh_q [N_STREAMS];
    logic [BYTE_W-1:0] byte_w [N_STREAMS];
    logic              wr_en;

    assign wr_en = sample_en && (bit_idx == '1);

    for (genvar s = 0; s < N_STREAMS; s++) begin : g_rx
        always_ff @(posedge clk) begin
            if (rst)            sh_q[s] <= '0;
            else if (sample_en) sh_q[s] <= {sh_q[s][BYTE_W-3:0], ser_in[s]};
        end
        assign byte_w[s]     = {sh_q[s], ser_in[s]};
        assign fetch_data[s] = mem[fetch_bank][fetch_addr[s]];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int s = 0; s < N_STREAMS; s++)
                mem[frame_par][{SW'(s), ch}] <= byte_w[s];
        end
    end

    assign cpu_data = mem[~frame_par][cpu_addr];

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en) else $error("store strobe longer than one clock"); // R2

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
    import tsi_pkg::*;
#(
    parameter int N_STREAMS  = N_STREAMS_D,
    parameter int N_CHANNELS = N_CHANNELS_D
) (
    input  logic                                            clk,
    input  logic                                            rst,
    input  logic                                            we,
    input  logic                                            sel_hi,
    input  logic [$clog2(N_STREAMS)+$clog2(N_CHANNELS)-1:0] waddr,
    input  logic [BYTE_W-1:0]                               wdata,
    input  logic [$clog2(N_CHANNELS)-1:0]                   ch,
    input  logic [$clog2(BYTE_W)-1:0]                       nxt_bit,
    input  logic [$clog2(N_CHANNELS)-1:0]                   nxt_ch,
    output logic [BYTE_W-1:0]                               lo_fetch [N_STREAMS],
    output conn_hi_t                                        hi_fetch [N_STREAMS],
    output logic                                            cst_out,
    input  logic [$clog2(N_STREAMS)+$clog2(N_CHANNELS)-1:0] cpu_addr,
    output logic [BYTE_W-1:0]                               cpu_lo,
    output conn_hi_t                                        cpu_hi
);
    localparam int SW      = $clog2(N_STREAMS);
    localparam int CW      = $clog2(N_CHANNELS);
    localparam int ENTRIES = N_STREAMS * N_CHANNELS;

    logic [BYTE_W-1:0] lo_mem [ENTRIES];
    conn_hi_t          hi_mem [ENTRIES];
    logic [CW-1:0]     load_ch;
    logic [CW-1:0]     cst_ch;
    logic              cst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                lo_mem[i] <= '0;
                hi_mem[i] <= '0;
            end
        end else if (we) begin
            if (sel_hi) hi_mem[waddr] <= hi_from_byte(wdata);
            else        lo_mem[waddr] <= wdata;
        end
    end

    // Loads at the end of a channel serve the following channel
    assign load_ch = CW'(ch + 1'b1);
    for (genvar s = 0; s < N_STREAMS; s++) begin : g_fetch
        assign lo_fetch[s] = lo_mem[{SW'(s), load_ch}];
        assign hi_fetch[s] = hi_mem[{SW'(s), load_ch}];
    end

    // Control stream: bit slot b carries stream b, one channel early
    assign cst_ch = CW'(nxt_ch + 1'b1);
    always_ff @(posedge clk) begin
        if (rst) cst_q <= 1'b0;
        else     cst_q <= hi_mem[{SW'(nxt_bit), cst_ch}].ctl;
    end
    assign cst_out = cst_q;

    assign cpu_lo = lo_mem[cpu_addr];
    assign cpu_hi = hi_mem[cpu_addr];

    AST_LO_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && !sel_hi) |=> (lo_mem[$past(waddr)] == $past(wdata))) else $error("low word write lost"); // R9

endmodule

// File: rtl/tsi_tx.sv
module tsi_tx
    import tsi_pkg::*;
#(
    parameter int N_STREAMS  = N_STREAMS_D,
    parameter int N_CHANNELS = N_CHANNELS_D
) (
    input  logic                                            clk,
    input  logic                                            rst,
    input  logic                                            chan_end,
    input  logic                                            bit_end,
    input  logic                                            glb_msg,
    input  logic                                            drive_en,
    input  logic [BYTE_W-1:0]                               lo_fetch [N_STREAMS],
    input  conn_hi_t                                        hi_fetch [N_STREAMS],
    input  logic [BYTE_W-1:0]                               dm_data  [N_STREAMS],
    output logic [$clog2(N_STREAMS)+$clog2(N_CHANNELS)-1:0] dm_addr  [N_STREAMS],
    output logic [N_STREAMS-1:0]                            ser_out,
    output logic [N_STREAMS-1:0]                            ser_oe
);
    localparam int AW = $clog2(N_STREAMS) + $clog2(N_CHANNELS);

    logic [BYTE_W-1:0]    sh_q [N_STREAMS];
    logic [N_STREAMS-1:0] oe_q;
    conn_hi_t             eff  [N_STREAMS];
    logic [BYTE_W-1:0]    word [N_STREAMS];

    for (genvar s = 0; s < N_STREAMS; s++) begin : g_tx
        assign dm_addr[s] = lo_fetch[s][AW-1:0];
        assign eff[s]     = hi_effective(hi_fetch[s], glb_msg);
        assign word[s]    = eff[s].msg ? lo_fetch[s] : dm_data[s];

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q[s] <= '0;
                oe_q[s] <= 1'b0;
            end else if (chan_end) begin
                sh_q[s] <= word[s];
                oe_q[s] <= eff[s].drive;
            end else if (bit_end) begin
                sh_q[s] <= {sh_q[s][BYTE_W-2:0], 1'b0};
            end
        end

        assign ser_out[s] = sh_q[s][BYTE_W-1];
    end

    assign ser_oe = oe_q & {N_STREAMS{drive_en}};

    AST_BCAST_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (chan_end && glb_msg) |=> (oe_q == '1)) else $error("broadcast left a driver off"); // R6
    AST_OE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !chan_end |=> $stable(oe_q)) else $error("enable changed inside a channel"); // R5

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int N_STREAMS    = N_STREAMS_D,
    parameter int N_CHANNELS   = N_CHANNELS_D,
    parameter int CLKS_PER_BIT = CLKS_PER_BIT_D
) (
    input  logic                                            clk,
    input  logic                                            rst,
    input  logic                                            frame_n,
    input  logic [N_STREAMS-1:0]                            ser_in,
    output logic [N_STREAMS-1:0]                            ser_out,
    output logic [N_STREAMS-1:0]                            ser_oe,
    output logic                                            cst_out,
    input  logic                                            glb_msg,
    input  logic                                            drive_en,
    input  logic                                            cm_we,
    input  logic                                            cm_sel_hi,
    input  logic [$clog2(N_STREAMS)+$clog2(N_CHANNELS)-1:0] cm_addr,
    input  logic [BYTE_W-1:0]                               cm_wdata,
    input  logic [1:0]                                      rd_sel,
    input  logic [$clog2(N_STREAMS)+$clog2(N_CHANNELS)-1:0] rd_addr,
    output logic [BYTE_W-1:0]                               rd_data
);
    localparam int CW = $clog2(N_CHANNELS);
    localparam int BW = $clog2(BYTE_W);
    localparam int AW = $clog2(N_STREAMS) + CW;

    logic [CW-1:0]     ch, nxt_ch;
    logic [BW-1:0]     bit_idx, nxt_bit;
    logic              sample_en, bit_end, chan_end, last_ch, frame_par, fetch_bank;
    logic [AW-1:0]     dm_addr  [N_STREAMS];
    logic [BYTE_W-1:0] dm_data  [N_STREAMS];
    logic [BYTE_W-1:0] lo_fetch [N_STREAMS];
    conn_hi_t          hi_fetch [N_STREAMS];
    logic [BYTE_W-1:0] cpu_dm, cpu_lo, rd_d;
    conn_hi_t          cpu_hi;

    tsi_timing #(.N_CHANNELS(N_CHANNELS), .CLKS_PER_BIT(CLKS_PER_BIT)) u_timing (
        .clk, .rst, .frame_n, .ch, .bit_idx, .nxt_ch, .nxt_bit,
        .sample_en, .bit_end, .chan_end, .last_ch, .frame_par
    );

    // Channel 0 of the next frame reads the bank closing now
    assign fetch_bank = last_ch ? frame_par : ~frame_par;

    tsi_rx_store #(.N_STREAMS(N_STREAMS), .N_CHANNELS(N_CHANNELS)) u_rx (
        .clk, .rst, .ser_in, .sample_en, .bit_idx, .ch, .frame_par, .fetch_bank,
        .fetch_addr(dm_addr), .fetch_data(dm_data), .cpu_addr(rd_addr), .cpu_data(cpu_dm)
    );

    tsi_conn_mem #(.N_STREAMS(N_STREAMS), .N_CHANNELS(N_CHANNELS)) u_conn (
        .clk, .rst, .we(cm_we), .sel_hi(cm_sel_hi), .waddr(cm_addr), .wdata(cm_wdata),
        .ch, .nxt_bit, .nxt_ch, .lo_fetch, .hi_fetch, .cst_out,
        .cpu_addr(rd_addr), .cpu_lo, .cpu_hi
    );

    tsi_tx #(.N_STREAMS(N_STREAMS), .N_CHANNELS(N_CHANNELS)) u_tx (
        .clk, .rst, .chan_end, .bit_end, .glb_msg, .drive_en,
        .lo_fetch, .hi_fetch, .dm_data, .dm_addr, .ser_out, .ser_oe
    );

    always_comb begin
        unique case (rd_sel_e'(rd_sel))
            RD_DATA:    rd_d = cpu_dm;
            RD_CONN_LO: rd_d = cpu_lo;
            RD_CONN_HI: rd_d = hi_to_byte(cpu_hi);
            default:    rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= rd_d;
    end

endmodule

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;
    localparam int NS    = 8;
    localparam int NC    = 32;
    localparam int FRAME = NC * 16;

    logic          clk = 1'b0;
    logic          rst, frame_n, glb_msg, drive_en, cm_we, cm_sel_hi, cst_out;
    logic [NS-1:0] ser_in, ser_out, ser_oe;
    logic [7:0]    cm_addr, cm_wdata, rd_addr, rd_data;
    logic [1:0]    rd_sel;

    always #10 clk = ~clk;

    tsi_switch #(.N_STREAMS(NS), .N_CHANNELS(NC), .CLKS_PER_BIT(2)) u_dut (
        .clk, .rst, .frame_n, .ser_in, .ser_out, .ser_oe, .cst_out, .glb_msg, .drive_en,
        .cm_we, .cm_sel_hi, .cm_addr, .cm_wdata, .rd_sel, .rd_addr, .rd_data
    );

    // {out stream[3], out channel[5], low word[8], high word raw[8]}
    localparam logic [23:0] VEC [8] = '{
        {3'd0, 5'd0,  8'h47, 8'h01},   // switched from s2 c7, driven
        {3'd0, 5'd31, 8'hFF, 8'h03},   // switched from s7 c31, driven, ctl
        {3'd1, 5'd5,  8'hA5, 8'h05},   // message, driven
        {3'd2, 5'd0,  8'h3C, 8'h04},   // message, driver off
        {3'd3, 5'd10, 8'h6A, 8'h03},   // loop of own address s3 c10
        {3'd7, 5'd0,  8'h1F, 8'h03},   // switched from s0 c31, ctl at frame wrap
        {3'd4, 5'd31, 8'hA0, 8'h07},   // message, driven, ctl
        {3'd6, 5'd16, 8'h5A, 8'hFA}    // upper bits dropped: keeps 3'b010
    };

    int         n_chk = 0, n_fail = 0;
    int         fr = 0, k = 0;
    logic       cur_glb = 1'b0, cur_drv = 1'b1;
    logic [7:0] m_lo [NS][NC];
    logic [2:0] m_hi [NS][NC];
    logic [7:0] rd_a;

    function automatic logic [7:0] pat(input int f, input int s, input int c);
        return 8'(((f * 37) + (s * 53) + (c * 11)) ^ ((f * s) + (c * c)));
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (frame %0d pos %0d)", req, act, exp, fr, k);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Checks and drives for position k, called at a falling edge
    task automatic pre();
        int c, b;
        logic       msg, en;
        logic [7:0] lo, exp_b;
        c = k / 16;
        b = (k / 2) % 8;
        cm_we = 1'b0;
        if (fr >= 1) begin
            for (int s = 0; s < NS; s++) begin
                lo  = m_lo[s][c];
                msg = cur_glb | m_hi[s][c][2];
                en  = cur_drv & (cur_glb | m_hi[s][c][0]);
                chk(!cur_drv ? "R7" : (cur_glb ? "R6" : "R5"), {7'd0, ser_oe[s]}, {7'd0, en});
                if (en) begin
                    exp_b = msg ? lo : pat(fr - 1, int'(lo[7:5]), int'(lo[4:0]));
                    chk(msg ? "R4" : "R1 R3", {7'd0, ser_out[s]}, {7'd0, exp_b[7-b]});
                end
            end
            chk("R8", {7'd0, cst_out}, {7'd0, m_hi[b][(c + 1) % NC][1]});
            if (k == 100) begin
                rd_a    = 8'((fr * 9 + 3) & 255);
                rd_sel  = 2'd0;
                rd_addr = rd_a;
            end
            if (k == 101)   // R2 storage seen through the read port
                chk("R2 R10", rd_data, pat(fr - 1, int'(rd_a[7:5]), int'(rd_a[4:0])));
        end
        for (int s = 0; s < NS; s++) begin
            exp_b     = pat(fr, s, c);
            ser_in[s] = exp_b[7-b];
        end
        frame_n = (k == FRAME - 1) ? 1'b0 : 1'b1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        k++;
        if (k == FRAME) begin
            k = 0;
            fr++;
        end
    endtask

    task automatic run_frame(input logic g, input logic d, input logic w,
                             input logic [7:0] wa, input logic [7:0] wd);
        for (int i = 0; i < FRAME; i++) begin
            pre();
            if (i == FRAME - 1) begin
                cur_glb = g; glb_msg = g;
                cur_drv = d; drive_en = d;
                if (w) begin
                    cm_we = 1'b1; cm_sel_hi = 1'b0; cm_addr = wa; cm_wdata = wd;
                    m_lo[wa[7:5]][wa[4:0]] = wd;
                end
            end
            tick();
        end
    endtask

    task automatic cm_write(input logic hi, input logic [7:0] a, input logic [7:0] d);
        cm_we = 1'b1; cm_sel_hi = hi; cm_addr = a; cm_wdata = d;
        @(posedge clk); @(negedge clk);
        cm_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] sel, input logic [7:0] a,
                            input logic [7:0] exp, input string req);
        rd_sel = sel; rd_addr = a;
        @(posedge clk); @(negedge clk);
        chk(req, rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        report();
        $finish;
    end

    initial begin
        rst = 1'b1; frame_n = 1'b1; ser_in = '0; glb_msg = 1'b0; drive_en = 1'b1;
        cm_we = 1'b0; cm_sel_hi = 1'b0; cm_addr = '0; cm_wdata = '0; rd_sel = '0; rd_addr = '0;
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++) begin
                m_lo[s][c] = '0;
                m_hi[s][c] = '0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", ser_oe, 8'h00);
        chk("R11", {7'd0, cst_out}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        cpu_read(2'd1, 8'h25, 8'h00, "R11");
        cpu_read(2'd2, 8'h25, 8'h00, "R11");
        chk("R11", ser_oe, 8'h00);

        // Connection set-up walked from the vector table
        for (int i = 0; i < 8; i++) begin
            cm_write(1'b0, VEC[i][23:16], VEC[i][15:8]);
            cm_write(1'b1, VEC[i][23:16], VEC[i][7:0]);
            m_lo[VEC[i][23:21]][VEC[i][20:16]] = VEC[i][15:8];
            m_hi[VEC[i][23:21]][VEC[i][20:16]] = VEC[i][2:0];
        end
        cpu_read(2'd2, {3'd6, 5'd16}, 8'h02, "R9");
        cpu_read(2'd1, {3'd6, 5'd16}, 8'h5A, "R9");
        cpu_read(2'd3, {3'd6, 5'd16}, 8'h00, "R10");

        // Realign with a frame pulse, then run frames
        frame_n = 1'b0;
        @(posedge clk); @(negedge clk);
        frame_n = 1'b1;
        k = 0; fr = 0;
        run_frame(1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
        run_frame(1'b0, 1'b1, 1'b1, {3'd1, 5'd5}, 8'h3E);   // R4 message rewrite
        run_frame(1'b1, 1'b1, 1'b0, 8'h00, 8'h00);          // R6 broadcast next
        run_frame(1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
        run_frame(1'b1, 1'b0, 1'b0, 8'h00, 8'h00);          // R7 drivers off over broadcast
        run_frame(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        run_frame(1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
        run_frame(1'b0, 1'b1, 1'b0, 8'h00, 8'h00);

        report();
        $finish;
    end

endmodule